// File: doc/BRIEF.md
# Shared Peripheral Interrupt Combiner

This block merges the interrupt requests of two peripherals, a parallel-I/O unit (source index 0) and a PWM unit (source index 1), onto one active-low request line that feeds a processor core. Each source owns a sticky pending flag. An event from the peripheral sets the flag. The flag is cleared by the acknowledge for that source or by a software clear. Software can also set a flag itself through a write-only force/clear port.

A mask register decides which pending flags may drive the shared line. Software can unmask sources one at a time, so a handler can let a chosen source interrupt it. One configuration pin selects the trigger style for all sources together. In level style the line stays low while any unmasked flag is set. In edge style the line gives a single one-cycle low pulse when the set of unmasked pending sources goes from empty to non-empty. Software then reads the pending outputs to find every source it must serve.

There is no data stream in this block. All pins are plain control and status signals and there is no valid/ready handshake.

Top module: `shared_irq_combiner`

## Requirements
- R1: After reset every pending flag is 0, every source is masked (mask register all 0) and `irq_n` is 1. Until the mask is written, events set pending flags but leave `irq_n` at 1.
- R2: A high `src_evt[i]` on a clock edge sets `pending[i]` after that edge. The flag then holds until it is cleared.
- R3: A high `src_ack[i]` clears `pending[i]` only. It has no effect on any other flag.
- R4: A cycle with `fc_wr` high sets every flag whose `fc_set` bit is 1 and clears every flag whose `fc_clr` bit is 1. When `fc_wr` is low, both fields are ignored.
- R5: When a set (event or force) and a clear (acknowledge or software clear) reach the same flag on the same edge, the set wins and the flag is 1.
- R6: A cycle with `mask_wr` high loads `mask_wdata` into the mask register. Mask bit i = 1 enables source i. A masked source keeps its pending flag but never drives `irq_n`.
- R7: With `level_sel` = 1 (level style), `irq_n` is 0 exactly while at least one source is both pending and unmasked. It returns to 1 only once every such source has been cleared.
- R8: With `level_sel` = 0 (edge style), `irq_n` is 0 for exactly one cycle: the cycle after an edge on which the unmasked-pending set went from empty to non-empty. Simultaneous events give only one pulse.
- R9: In edge style no further pulse occurs while any unmasked source stays pending. A new pulse needs all unmasked pending flags to be cleared and then a new unmasked pending flag to appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_sel | input | 1 | 1 = level style, 0 = edge style (applies to all sources) |
| src_evt | input | N_SRC | Event strobes from the peripherals (bit 0 parallel-I/O, bit 1 PWM) |
| src_ack | input | N_SRC | Per-source acknowledge strobes |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | N_SRC | New mask value, 1 = source enabled |
| fc_wr | input | 1 | Write strobe for the force/clear register |
| fc_set | input | N_SRC | Per-source force bits |
| fc_clr | input | N_SRC | Per-source clear bits |
| irq_n | output | 1 | Shared active-low interrupt request |
| pending | output | N_SRC | Per-source pending flags |

## Verification
Two kinds of collision are checked. The first is a set and a clear landing on the same flag in the same cycle: an event together with its acknowledge, or a forced set together with a software clear. The second is both sources firing together, which in edge style has to merge into one pulse and in level style has to hold the line until the second acknowledge. The bench sweeps both trigger styles, every mask value and every non-empty event pattern, and acknowledges the sources one at a time. Directed steps then force the collision cases. A reference model built from the requirements predicts `pending` and `irq_n` after each edge.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  typedef enum logic [0:0] {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  localparam int SRC_PIO = 0;
  localparam int SRC_PWM = 1;
endpackage

// File: rtl/shirq_pend_cell.sv
module shirq_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  // set has priority so that no event is lost
  always_ff @(posedge clk) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o); // R5
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_o); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(pend_o)); // R2
endmodule

// File: rtl/shirq_mask_reg.sv
module shirq_mask_reg #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] mask_o
);
  logic [N_SRC-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_o)); // R6
  AST_MASK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_o == '0)); // R1
endmodule

// File: rtl/shirq_line_gen.sv
module shirq_line_gen
  import shirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_sel,
  input  logic active_i,
  output logic irq_n
);
  trig_e mode;
  logic  active_d;

  assign mode = trig_e'(level_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) active_d <= 1'b0;
    else        active_d <= active_i;
  end

  always_comb begin
    if (mode == TRIG_LEVEL) irq_n = ~active_i;
    else                    irq_n = ~(active_i & ~active_d);
  end

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_sel && !irq_n) |=> (irq_n || level_sel)); // R8
  AST_EDGE_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_sel && active_i && $past(active_i)) |-> irq_n); // R9
endmodule

// File: rtl/shared_irq_combiner.sv
module shared_irq_combiner #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_sel,
  input  logic [N_SRC-1:0] src_evt,
  input  logic [N_SRC-1:0] src_ack,
  input  logic             mask_wr,
  input  logic [N_SRC-1:0] mask_wdata,
  input  logic             fc_wr,
  input  logic [N_SRC-1:0] fc_set,
  input  logic [N_SRC-1:0] fc_clr,
  output logic             irq_n,
  output logic [N_SRC-1:0] pending
);
  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] clr_vec;
  logic [N_SRC-1:0] mask_q;
  logic             any_active;

  assign set_vec = src_evt | ({N_SRC{fc_wr}} & fc_set);
  assign clr_vec = src_ack | ({N_SRC{fc_wr}} & fc_clr);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    shirq_pend_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .pend_o (pending[i])
    );
  end

  shirq_mask_reg #(.N_SRC(N_SRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_wr),
    .wdata_i (mask_wdata),
    .mask_o  (mask_q)
  );

  assign any_active = |(pending & mask_q);

  shirq_line_gen u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_sel (level_sel),
    .active_i  (any_active),
    .irq_n     (irq_n)
  );

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (level_sel && ((pending & mask_q) != '0)) |-> !irq_n); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & mask_q) == '0) |-> irq_n); // R6
endmodule

// File: tb/shared_irq_combiner_test.sv
`timescale 1ns/1ps
module shared_irq_combiner_test;
  import shirq_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       level_sel;
  logic [1:0] src_evt, src_ack, mask_wdata, fc_set, fc_clr;
  logic       mask_wr, fc_wr;
  logic       irq_n;
  logic [1:0] pending;

  int checks = 0;
  int errors = 0;

  logic [1:0] m_pend, m_mask;
  logic       m_act_d;

  always #2 clk = ~clk;

  shared_irq_combiner #(.N_SRC(2)) uut (
    .clk(clk), .rst_n(rst_n), .level_sel(level_sel),
    .src_evt(src_evt), .src_ack(src_ack),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .fc_wr(fc_wr), .fc_set(fc_set), .fc_clr(fc_clr),
    .irq_n(irq_n), .pending(pending)
  );

  task automatic check(input string tag, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // one clock step: drive at negedge, update model at posedge, check after it
  task automatic step(input logic [1:0] e, input logic [1:0] a,
                      input logic fw, input logic [1:0] fs, input logic [1:0] fc,
                      input logic mw, input logic [1:0] md,
                      input string tag_p, input string tag_i);
    logic act;
    logic exp_irq;
    @(negedge clk);
    src_evt = e; src_ack = a; fc_wr = fw; fc_set = fs; fc_clr = fc;
    mask_wr = mw; mask_wdata = md;
    @(posedge clk);
    m_act_d = |(m_pend & m_mask);
    m_pend  = (m_pend & ~(a | (fw ? fc : 2'b00))) | e | (fw ? fs : 2'b00);
    if (mw) m_mask = md;
    #1;
    act     = |(m_pend & m_mask);
    exp_irq = level_sel ? !act : !(act && !m_act_d);
    check(tag_p, "pending", pending, m_pend);
    check(tag_i, "irq_n", {1'b0, irq_n}, {1'b0, exp_irq});
  endtask

  task automatic idle(input string tag);
    step(2'b00, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, tag, tag);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; level_sel = 1'b1;
    src_evt = '0; src_ack = '0; fc_wr = 1'b0; fc_set = '0; fc_clr = '0;
    mask_wr = 1'b0; mask_wdata = '0;
    m_pend = '0; m_mask = '0; m_act_d = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check("R1", "pending after reset", pending, 2'b00);
    check("R1", "irq_n after reset", {1'b0, irq_n}, 2'b01);

    // R1: both sources masked after reset, line stays quiet
    step(2'b11, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, "R2", "R1");
    idle("R1");
    // R4: clear via software, and fc fields ignored without strobe
    step(2'b00, 2'b00, 1'b0, 2'b00, 2'b11, 1'b0, 2'b00, "R4", "R4");
    step(2'b00, 2'b00, 1'b1, 2'b00, 2'b11, 1'b0, 2'b00, "R4", "R4");
    step(2'b00, 2'b00, 1'b0, 2'b11, 2'b00, 1'b0, 2'b00, "R4", "R4");
    step(2'b00, 2'b00, 1'b1, 2'b10, 2'b00, 1'b0, 2'b00, "R4", "R4");
    step(2'b00, 2'b00, 1'b1, 2'b00, 2'b10, 1'b0, 2'b00, "R4", "R4");

    // sweep: style x mask x event pattern
    for (int md = 0; md < 2; md++) begin
      for (int mk = 0; mk < 4; mk++) begin
        for (int ev = 1; ev < 4; ev++) begin
          string ti;
          @(negedge clk); level_sel = md[0];
          ti = (mk == 0) ? "R6" : (md == 1 ? "R7" : "R8");
          step(2'b00, 2'b00, 1'b1, 2'b00, 2'b11, 1'b1, mk[1:0], "R4", "R6");
          idle("R6");
          step(ev[1:0], 2'b00, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, "R2", ti);
          idle(md == 1 ? ti : "R9");
          step(2'b00, ev[1:0] & 2'b01, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, "R3", ti);
          step(2'b00, ev[1:0] & 2'b10, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, "R3", ti);
        end
      end
    end

    // R5: set and clear collide on one flag
    @(negedge clk); level_sel = 1'b1;
    step(2'b00, 2'b00, 1'b1, 2'b00, 2'b11, 1'b1, 2'b11, "R6", "R6");
    step(2'b01, 2'b01, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, "R5", "R7");
    step(2'b00, 2'b00, 1'b1, 2'b10, 2'b11, 1'b0, 2'b00, "R5", "R7");
    step(2'b10, 2'b01, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, "R3", "R7");
    step(2'b00, 2'b10, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, "R3", "R7");

    // R9: edge style retrigger rules
    @(negedge clk); level_sel = 1'b0;
    idle("R9");
    step(2'b01, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, "R2", "R8");
    step(2'b10, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, "R2", "R9");
    step(2'b00, 2'b01, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, "R3", "R9");
    step(2'b01, 2'b10, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, "R9", "R9");
    step(2'b00, 2'b01, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, "R3", "R9");
    step(2'b10, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0, 2'b00, "R2", "R9");
    // R6: masking a pending source quiets it, unmasking retriggers
    step(2'b00, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, 2'b01, "R6", "R6");
    step(2'b00, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, 2'b11, "R6", "R6");
    idle("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule